// File: doc/BRIEF.md
# Row Scan Controller with Stall Watchdog

This block drives the row-select lines of a multiplexed LED matrix. It holds a 4-bit active row index and drives it out as a one-hot 16-bit row select. A frame memory uses the same index to choose which row of pixel data to stream.

The row index comes from one of two sources, chosen by `ext_mode`:

- **Internal mode.** A sequencer steps the index by one on each PWM period-start pulse. It wraps back to row 0 after the last enabled row. `full_rows` chooses an 8-row or a 16-row scan.
- **External mode.** The index is taken directly from a 4-bit row address input. All 16 rows are reachable in this mode.

A watchdog counts clock cycles since the row index last changed. If the index stays the same for `TIMEOUT` cycles, the display is blanked and all row selects are driven inactive. The default `TIMEOUT` is sized for about 0.3 s at 100 MHz. The next change of the row index clears the blank and restarts the count.

Top module: `row_scan_ctl`

## Requirements
- R1: While reset is held, and after its release until the first clock edge, `row_idx` is 0, `row_sel` is 16'h0001 and `blank` is 0.
- R2: `row_sel` never has more than one bit set. When `blank` is 0, exactly bit `row_idx` of `row_sel` is set.
- R3: In internal mode (`ext_mode`=0), a clock edge with `period_start`=1 moves `row_idx` to the next row. An edge with `period_start`=0 leaves `row_idx` unchanged.
- R4: In internal mode with `full_rows`=0, an advance from row 7 goes to row 0. The scan uses rows 0 to 7 only.
- R5: In internal mode with `full_rows`=1, an advance from row 15 goes to row 0. The scan uses rows 0 to 15.
- R6: In internal mode with `full_rows`=0, an advance from any row above 7 goes to row 0.
- R7: In external mode (`ext_mode`=1), `row_idx` equals the `row_addr` value sampled at the previous clock edge. `period_start` and `full_rows` have no effect in this mode.
- R8: When `row_idx` has not changed for `TIMEOUT` consecutive clock edges, `blank` rises and `row_sel` goes to 0. `row_idx` keeps its value.
- R9: The clock edge that changes `row_idx` clears `blank` and restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1: row index from `row_addr`; 0: internal sequencer |
| full_rows | input | 1 | Internal scan length: 0 gives 8 rows, 1 gives 16 rows |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| row_addr | input | 4 | External row address |
| row_sel | output | 16 | One-hot row select, all zero while blanked |
| row_idx | output | 4 | Current row index for the frame memory |
| blank | output | 1 | Display-off flag raised by the watchdog |

## Verification
External mode is swept over all 16 addresses. During the sweep, `period_start` and `full_rows` are toggled on purpose, so any leak of those inputs into external decoding would show up.

Internal mode is driven with period-start pulses spaced apart by idle cycles. This separates advancing from holding. It is run through several wraps in both the 8-row and 16-row settings. One run enters the 8-row setting from row 15, to check the out-of-range wrap.

The watchdog is stalled in both modes. Its output is sampled one edge before and exactly at the expected timeout. It is then released by a row change, which checks that the timeout count restarts.

// File: rtl/row_scan_ctl.sv
module row_scan_ctl #(
  parameter int TIMEOUT = 30_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        full_rows,
  input  logic        period_start,
  input  logic [3:0]  row_addr,
  output logic [15:0] row_sel,
  output logic [3:0]  row_idx,
  output logic        blank
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [3:0]    cur, last_row, step, nxt;
  logic [CW-1:0] idle_cnt;
  logic          moved;

  assign last_row = full_rows ? 4'd15 : 4'd7;
  assign step     = (cur >= last_row) ? 4'd0 : cur + 4'd1;
  assign nxt      = ext_mode ? row_addr : (period_start ? step : cur);
  assign moved    = (nxt != cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      idle_cnt <= '0;
      blank    <= 1'b0;
    end else begin
      cur <= nxt;
      if (moved) begin
        idle_cnt <= '0;
        blank    <= 1'b0;
      end else if (!blank) begin
        if (idle_cnt == CW'(TIMEOUT - 1)) blank <= 1'b1;
        else idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign row_idx = cur;
  assign row_sel = blank ? 16'h0000 : (16'h0001 << cur);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));
  // R2
  sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> ($countones(row_sel) == 1 && row_sel[row_idx]));
  // R3
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !period_start) |=> $stable(row_idx));
  // R4
  wrap8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && period_start && !full_rows && row_idx == 4'd7) |=> row_idx == 4'd0);
  // R5
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && period_start && full_rows && row_idx == 4'd15) |=> row_idx == 4'd0);
  // R7
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> row_idx == $past(row_addr));
  // R9
  move_unblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_idx != $past(row_idx)) |-> !blank);
  // R8
  blank_hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank) |-> $stable(row_idx));
endmodule

// File: tb/row_scan_ctl_bench.sv
module row_scan_ctl_bench;
  localparam int TO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0, full_rows = 1'b0, period_start = 1'b0;
  logic [3:0]  row_addr = '0;
  logic [15:0] row_sel;
  logic [3:0]  row_idx;
  logic        blank;
  int          n_chk = 0, n_bad = 0;
  int          expv = 0;

  row_scan_ctl #(.TIMEOUT(TO)) u_row_scan_ctl (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .full_rows(full_rows),
    .period_start(period_start), .row_addr(row_addr),
    .row_sel(row_sel), .row_idx(row_idx), .blank(blank));

  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_row(input string req, input int e);
    chk(row_idx == 4'(e), req, row_idx, e);
    chk(row_sel == (16'h1 << e) && !blank, {req, " R2 sel"}, row_sel, 16'h1 << e);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    chk(row_idx == 0, "R1 idx", row_idx, 0);
    chk(row_sel == 16'h1, "R1 sel", row_sel, 1);
    chk(blank == 0, "R1 blank", blank, 0);
    rst_n = 1'b1;
    chk(row_idx == 0 && row_sel == 16'h1 && !blank, "R1 after release", row_sel, 1);

    // R7: external sweep with distractor inputs
    ext_mode = 1'b1;
    for (int a = 0; a < 16; a++) begin
      row_addr = 4'(15 - a); period_start = a[0]; full_rows = a[1];
      tick();
      chk_row("R7", 15 - a);
    end
    for (int a = 0; a < 16; a++) begin
      row_addr = 4'(a); period_start = ~a[0]; full_rows = ~a[2];
      tick();
      chk_row("R7", a);
    end

    // R6: 8-row mode entered from row 15
    ext_mode = 1'b0; full_rows = 1'b0; period_start = 1'b1;
    tick();
    chk_row("R6", 0);
    expv = 0;
    // R3 R4
    for (int i = 0; i < 40; i++) begin
      period_start = (i % 2 == 0);
      tick();
      if (i % 2 == 0) expv = (expv >= 7) ? 0 : expv + 1;
      chk_row("R3 R4", expv);
    end
    // R5
    full_rows = 1'b1;
    for (int i = 0; i < 70; i++) begin
      period_start = (i % 3 == 0);
      tick();
      if (i % 3 == 0) expv = (expv >= 15) ? 0 : expv + 1;
      chk_row("R3 R5", expv);
    end

    // R8 internal stall
    period_start = 1'b1; tick(); expv = (expv >= 15) ? 0 : expv + 1;
    period_start = 1'b0;
    for (int j = 1; j < TO; j++) tick();
    chk(blank == 0, "R8 before timeout", blank, 0);
    tick();
    chk(blank == 1, "R8 at timeout", blank, 1);
    chk(row_sel == 0, "R8 sel off", row_sel, 0);
    chk(row_idx == 4'(expv), "R8 idx kept", row_idx, expv);
    for (int j = 0; j < 10; j++) tick();
    chk(blank == 1 && row_sel == 0, "R8 stays off", row_sel, 0);
    // R9
    period_start = 1'b1; tick(); expv = (expv >= 15) ? 0 : expv + 1;
    period_start = 1'b0;
    chk_row("R9 clear", expv);
    for (int j = 1; j < TO; j++) tick();
    chk(blank == 0, "R9 restart", blank, 0);
    tick();
    chk(blank == 1, "R9 second timeout", blank, 1);

    // R8 R9 external stall
    ext_mode = 1'b1; row_addr = 4'd9; tick();
    chk_row("R9 ext clear", 9);
    for (int j = 1; j < TO; j++) begin
      period_start = j[0]; tick();
    end
    chk(blank == 0, "R8 ext before", blank, 0);
    tick();
    chk(blank == 1 && row_sel == 0, "R8 ext timeout", row_sel, 0);
    row_addr = 4'd12; tick();
    chk_row("R9 ext move", 12);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule